// File: doc/BRIEF.md
# SRAM Low-Voltage Retention Sequencer

This block protects a battery-backed static RAM while its supply is lowered. On a power-down request it first waits for the memory controller to report idle. It then drives the RAM selects to a retention pattern, and only after that raises a flag saying the supply may be lowered. If the supply-good indication falls while accesses are still allowed, the block applies the retention pattern at once, whether or not the controller is idle, because the deselect must be in place no later than the moment the supply begins to fall.

When the supply is good again and the request has been withdrawn, the block holds the selects in the retention pattern. It blocks accesses until a recovery window of at least `RECOVER_MS` whole milliseconds has passed, counted with an external millisecond tick. The same lockout applies after reset. A loss of supply during the wait returns the block to retention, and the count starts again.

A parameter picks the retention method:
- by the active-high select driven low;
- by the active-low select driven high, with the active-high select held at a firm level;
- by both active-low byte selects driven high, with the chip selects left enabled.

Top module: `rsq_retention_seq`

## Requirements
- R1: During and straight after reset, `access_ok` and `ret_active` are 0 and the selects show the retention pattern. The block is in its recovery wait.
- R2: In the recovery wait, with `supply_ok` held high, `access_ok` rises in the cycle after the (RECOVER_MS+1)-th `ms_tick` and not before. The first interval may be partial, so this guarantees at least RECOVER_MS whole milliseconds.
- R3: When `access_ok` is 1 and `pd_req` and `ctrl_idle` are both high at a clock edge:
  - in the next cycle, the selects show the retention pattern and `access_ok` is 0;
  - `ret_active` rises one cycle after that.
- R4: While `ctrl_idle` is low, a `pd_req` has no effect. `access_ok` stays 1 and the selects keep the access pattern.
- R5: If `supply_ok` is low while `access_ok` is 1, the next cycle shows the retention pattern and `access_ok` is 0, whatever the value of `ctrl_idle`. `ret_active` follows one cycle later.
- R6: Once `ret_active` is 1, it stays 1 for as long as `supply_ok` is low or `pd_req` is high. It falls in the cycle after both `supply_ok` is high and `pd_req` is low, and the recovery wait begins.
- R7: If `supply_ok` falls during the recovery wait, `ret_active` is 1 in the next cycle. The recovery count restarts from zero when the supply returns.
- R8: An `ms_tick` outside the recovery wait has no effect on the recovery count.
- R9: The output word is {sel_hi, sel_n, byte_n[1:0]}.
  - The access pattern is 4'b1000.
  - The retention pattern is 4'b0111 for method 0 (active-high select), 4'b1111 for method 1 (active-low select), and 4'b1011 for method 2 (byte selects).
- R10: `access_ok` and `ret_active` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | Power-down request |
| supply_ok | input | 1 | RAM supply is at operating level |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| ctrl_idle | input | 1 | Memory controller has no access in progress |
| ram_sel_hi | output | 1 | Level for the RAM active-high chip select |
| ram_sel_n | output | 1 | Level for the RAM active-low chip select |
| ram_byte_n | output | 2 | Levels for the RAM active-low byte selects |
| ret_active | output | 1 | Retention held; supply may be lowered |
| access_ok | output | 1 | Memory controller may start accesses |

## Verification
A wrong state register shows at the ports in the very next cycle, because all four flag and select outputs decode it directly. Entering retention too early drops `access_ok` or moves the select word. Leaving it too early raises `access_ok` before the tick count is complete. A recovery counter that is off by one, or not cleared, shows as `access_ok` rising one tick early or late relative to the bench's own tick count. This is why every tick is followed by a check of `access_ok`. The three method variants run side by side on the same stimulus, so a wrong retention pattern shows as a mismatch on the select word.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_ENTER   = 2'd1,
        ST_RETAIN  = 2'd2,
        ST_RECOVER = 2'd3
    } rsq_state_e;

    typedef enum logic [1:0] {
        RET_BY_HI   = 2'd0,
        RET_BY_LO   = 2'd1,
        RET_BY_BYTE = 2'd2
    } rsq_method_e;

    typedef struct packed {
        logic       sel_hi;
        logic       sel_n;
        logic [1:0] byte_n;
    } rsq_sel_t;

    localparam rsq_sel_t SEL_ACCESS = '{sel_hi: 1'b1, sel_n: 1'b0, byte_n: 2'b00};

endpackage

// File: rtl/rsq_ms_counter.sv
module rsq_ms_counter #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        done = 1'b0;
        if (!run) begin
            r_d.cnt = '0;
        end else if (tick) begin
            if (r_q.cnt == CW'(LIMIT)) begin
                done = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R2: the count never passes its limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CW'(LIMIT));

    // R7 / R8: outside the recovery wait the count is held at zero
    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> r_q.cnt == '0);

endmodule

// File: rtl/rsq_select_drive.sv
module rsq_select_drive
    import rsq_pkg::*;
#(
    parameter rsq_method_e METHOD = RET_BY_HI
) (
    input  logic     hold,
    output rsq_sel_t sel
);
    rsq_sel_t ret_pat;

    generate
        if (METHOD == RET_BY_HI) begin : g_hi
            assign ret_pat = '{sel_hi: 1'b0, sel_n: 1'b1, byte_n: 2'b11};
        end else if (METHOD == RET_BY_LO) begin : g_lo
            // active-high select kept firmly at a rail while the low one deselects
            assign ret_pat = '{sel_hi: 1'b1, sel_n: 1'b1, byte_n: 2'b11};
        end else begin : g_byte
            assign ret_pat = '{sel_hi: 1'b1, sel_n: 1'b0, byte_n: 2'b11};
        end
    endgenerate

    always_comb begin
        sel = hold ? ret_pat : SEL_ACCESS;
    end

    always_comb begin
        assert (hold || sel.byte_n == 2'b00);
    end

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       supply_ok,
    input  logic       ctrl_idle,
    input  logic       cnt_done,
    output rsq_state_e state,
    output logic       ret_flag,
    output logic       acc_flag
);
    typedef struct packed {
        rsq_state_e st;
        logic       ret;
        logic       acc;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_ACTIVE: begin
                if (!supply_ok)                r_d.st = ST_ENTER;
                else if (pd_req && ctrl_idle)  r_d.st = ST_ENTER;
            end
            ST_ENTER: begin
                r_d.st = ST_RETAIN;
            end
            ST_RETAIN: begin
                if (supply_ok && !pd_req)      r_d.st = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (!supply_ok)                r_d.st = ST_RETAIN;
                else if (cnt_done)             r_d.st = ST_ACTIVE;
            end
            default: r_d.st = ST_RECOVER;
        endcase
        r_d.ret = (r_d.st == ST_RETAIN);
        r_d.acc = (r_d.st == ST_ACTIVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_RECOVER;
            r_q.ret <= 1'b0;
            r_q.acc <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state    = r_q.st;
    assign ret_flag = r_q.ret;
    assign acc_flag = r_q.acc;

    // R5: a supply drop while active forces the entry step
    p_enter_on_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACTIVE && !supply_ok) |=> r_q.st == ST_ENTER);

    // R4: a request against a busy controller keeps accesses allowed
    p_defer_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACTIVE && supply_ok && pd_req && !ctrl_idle) |=> r_q.acc);

    // R2: accesses open only at the end of a complete recovery count
    p_open_after_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.acc) |-> $past(r_q.st == ST_RECOVER && cnt_done));

    // R10: both flags never high together
    p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.acc && r_q.ret));

endmodule

// File: rtl/rsq_retention_seq.sv
module rsq_retention_seq
    import rsq_pkg::*;
#(
    parameter rsq_method_e METHOD     = RET_BY_HI,
    parameter int          RECOVER_MS = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       supply_ok,
    input  logic       ms_tick,
    input  logic       ctrl_idle,
    output logic       ram_sel_hi,
    output logic       ram_sel_n,
    output logic [1:0] ram_byte_n,
    output logic       ret_active,
    output logic       access_ok
);
    rsq_state_e state;
    logic       cnt_done;
    logic       in_recover;
    logic       hold_sel;
    rsq_sel_t   sel;

    assign in_recover = (state == ST_RECOVER);
    assign hold_sel   = (state != ST_ACTIVE);

    rsq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (pd_req),
        .supply_ok (supply_ok),
        .ctrl_idle (ctrl_idle),
        .cnt_done  (cnt_done),
        .state     (state),
        .ret_flag  (ret_active),
        .acc_flag  (access_ok)
    );

    rsq_ms_counter #(.LIMIT(RECOVER_MS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_recover),
        .tick  (ms_tick),
        .done  (cnt_done)
    );

    rsq_select_drive #(.METHOD(METHOD)) u_sel (
        .hold (hold_sel),
        .sel  (sel)
    );

    assign ram_sel_hi = sel.sel_hi;
    assign ram_sel_n  = sel.sel_n;
    assign ram_byte_n = sel.byte_n;

    // R3: the deselect pattern is already on the pins when the flag rises
    p_sel_before_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_active) |-> ($past(ram_byte_n) == 2'b11 && !$past(access_ok)));

    // R9: accesses allowed only with the access pattern
    p_access_pattern_r9: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> (ram_byte_n == 2'b00 && ram_sel_hi && !ram_sel_n));

    // R6: retention holds while the supply is down
    p_retain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_active && !supply_ok) |=> ret_active);

    // R7: a supply loss in the recovery wait returns to retention
    p_recover_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_ok && !ret_active && ram_byte_n == 2'b11 && !supply_ok
         && $past(!access_ok && !ret_active)) |=> ret_active);

endmodule

// File: tb/rsq_retention_seq_tb.sv
module rsq_retention_seq_tb;
    import rsq_pkg::*;

    localparam int MS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req = 1'b0;
    logic supply_ok = 1'b1;
    logic ms_tick = 1'b0;
    logic ctrl_idle = 1'b1;

    logic       hi_a, n_a, ret_a, acc_a;
    logic [1:0] b_a;
    logic       hi_b, n_b, ret_b, acc_b;
    logic [1:0] b_b;
    logic       hi_c, n_c, ret_c, acc_c;
    logic [1:0] b_c;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rsq_retention_seq #(.METHOD(RET_BY_HI), .RECOVER_MS(MS)) u_dut (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .supply_ok(supply_ok),
        .ms_tick(ms_tick), .ctrl_idle(ctrl_idle),
        .ram_sel_hi(hi_a), .ram_sel_n(n_a), .ram_byte_n(b_a),
        .ret_active(ret_a), .access_ok(acc_a));

    rsq_retention_seq #(.METHOD(RET_BY_LO), .RECOVER_MS(MS)) u_dut_lo (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .supply_ok(supply_ok),
        .ms_tick(ms_tick), .ctrl_idle(ctrl_idle),
        .ram_sel_hi(hi_b), .ram_sel_n(n_b), .ram_byte_n(b_b),
        .ret_active(ret_b), .access_ok(acc_b));

    rsq_retention_seq #(.METHOD(RET_BY_BYTE), .RECOVER_MS(MS)) u_dut_byte (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .supply_ok(supply_ok),
        .ms_tick(ms_tick), .ctrl_idle(ctrl_idle),
        .ram_sel_hi(hi_c), .ram_sel_n(n_c), .ram_byte_n(b_c),
        .ret_active(ret_c), .access_ok(acc_c));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    // flags of all three variants, plus the R10 exclusivity check
    task automatic chk_flags(input string tag, input bit acc, input bit ret);
        chk({tag, " access_ok"},  {acc_a, acc_b, acc_c}, {acc, acc, acc});
        chk({tag, " ret_active"}, {ret_a, ret_b, ret_c}, {ret, ret, ret});
        chk("R10 flags exclusive", int'(acc_a & ret_a), 0);
    endtask

    // R9 encodings: access 4'b1000; retention 0111 / 1111 / 1011
    task automatic chk_sel(input string tag, input bit retn);
        chk({tag, " sel method0"}, {hi_a, n_a, b_a}, retn ? 4'b0111 : 4'b1000);
        chk({tag, " sel method1"}, {hi_b, n_b, b_b}, retn ? 4'b1111 : 4'b1000);
        chk({tag, " sel method2"}, {hi_c, n_c, b_c}, retn ? 4'b1011 : 4'b1000);
    endtask

    // R2: expect exactly MS+1 ticks before accesses open
    task automatic recover_count(input string tag);
        for (int i = 0; i < MS; i++) begin
            tick();
            chk({tag, " still locked"}, int'(acc_a), 0);
        end
        tick();
        chk_flags({tag, " opened"}, 1'b1, 1'b0);
        chk_sel({tag, " R9 access"}, 1'b0);
    endtask

    task automatic t_reset();
        chk_flags("R1 in reset", 1'b0, 1'b0);
        chk_sel("R1 R9 in reset", 1'b1);
        rst_n = 1'b1;
        step(1);
        chk_flags("R1 after reset", 1'b0, 1'b0);
        chk_sel("R1 R9 after reset", 1'b1);
    endtask

    task automatic t_defer_then_enter();
        ctrl_idle = 1'b0;
        pd_req    = 1'b1;
        step(3);
        chk_flags("R4 busy defers", 1'b1, 1'b0);
        chk_sel("R4 busy pattern", 1'b0);
        ctrl_idle = 1'b1;
        step(1);
        chk_flags("R3 entry step", 1'b0, 1'b0);
        chk_sel("R3 R9 entry", 1'b1);
        step(1);
        chk_flags("R3 retention flag", 1'b0, 1'b1);
        chk_sel("R9 retention", 1'b1);
    endtask

    task automatic t_retain_hold();
        supply_ok = 1'b0;
        step(2);
        chk_flags("R6 supply low", 1'b0, 1'b1);
        supply_ok = 1'b1;
        step(2);
        chk_flags("R6 request still high", 1'b0, 1'b1);
        for (int i = 0; i < MS + 3; i++) tick();
        chk_flags("R8 ticks in retention", 1'b0, 1'b1);
        pd_req = 1'b0;
        step(1);
        chk_flags("R6 leave retention", 1'b0, 1'b0);
        chk_sel("R6 R9 recovery pattern", 1'b1);
    endtask

    task automatic t_recover_abort();
        for (int i = 0; i < MS; i++) begin
            tick();
            chk("R8 earlier ticks ignored", int'(acc_a), 0);
        end
        supply_ok = 1'b0;
        step(1);
        chk_flags("R7 drop in recovery", 1'b0, 1'b1);
        supply_ok = 1'b1;
        step(1);
        chk_flags("R7 supply back", 1'b0, 1'b0);
        recover_count("R7 restart count");
    endtask

    task automatic t_supply_drop_active();
        ctrl_idle = 1'b0;
        supply_ok = 1'b0;
        step(1);
        chk_flags("R5 forced entry", 1'b0, 1'b0);
        chk_sel("R5 forced pattern", 1'b1);
        step(1);
        chk_flags("R5 retention flag", 1'b0, 1'b1);
        supply_ok = 1'b1;
        ctrl_idle = 1'b1;
        step(1);
        recover_count("R5 R2 recovery");
    endtask

    initial begin
        step(2);
        t_reset();
        recover_count("R2 power-up");
        t_defer_then_enter();
        t_retain_hold();
        t_recover_abort();
        t_supply_drop_active();
        step(2);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule